// File: doc/BRIEF.md
# Multiplexed-Bus Machine Cycle Sequencer

This block runs one bus machine cycle for an 8-bit processor whose low address byte and data byte share the same eight lines. A caller raises a start strobe with a cycle kind, a 16-bit address and, for writes, a data byte. The sequencer then steps through the T-states of that kind. It drives the address-latch pulse, the active-low read and write strobes, the IO/memory select and the two status bits. It captures the returned byte on reads and pulses a done flag when the cycle ends.

The incoming clock is halved internally. Every T-state spans two input clocks, and the halved clock is driven out for the rest of the system. The shared lines appear as a separate output, output-enable and input, so an external tri-state pad or a latch can be attached. The address and write data are latched when a cycle is accepted. The caller may therefore change them while the cycle runs.

Top module: `mux_bus_cycle_seq`

## Requirements
- R1: While reset is held and right after it, rd_n=1, wr_n=1, ale=0, ad_oe=0, io_m=0, {s1,s0}=00 and done=0.
- R2: cpu_clk changes value on every input clock. Each T-state lasts exactly two input clocks.
- R3: cyc_kind codes are 0 opcode fetch, 1 memory read, 2 memory write, 3 IO read and 4 IO write. A start is accepted only while idle and only with codes 0 to 4. Codes 5 to 7 start nothing, and a start raised during a cycle has no effect.
- R4: In T1, addr_hi carries addr[15:8], ad_out carries addr[7:0], ad_oe=1, ale=1, and both strobes are high.
- R5: io_m is 1 for the IO kinds and 0 for the memory kinds during the whole cycle. {s1,s0} is 11 for opcode fetch, 10 for memory or IO read, and 01 for memory or IO write, and it holds for every T-state.
- R6: For the read kinds, rd_n is low in T2 and T3 only, while ad_oe=0, ale=0 and wr_n=1.
- R7: rdata takes ad_in on the last input clock of T3 of a read kind. rdata keeps its value at all other times.
- R8: For the write kinds, wr_n is low in T2 and T3, ad_oe=1, ad_out carries the write byte, and rd_n stays high.
- R9: An opcode fetch adds a fourth T-state. In it both strobes are high, ad_oe=0 and the status stays 11. All other kinds end after T3.
- R10: done is high for exactly one input clock right after the final T-state, with the bus already idle. A start held high is accepted two input clocks after done.
- R11: The address and write byte are latched when a cycle is accepted, and addr_hi holds the high byte for all of its T-states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a machine cycle |
| cyc_kind | input | 3 | Kind of machine cycle (codes in R3) |
| addr | input | 16 | Cycle address |
| wdata | input | 8 | Byte to write |
| ad_in | input | 8 | Shared lines as seen from the bus |
| cpu_clk | output | 1 | Halved clock output |
| addr_hi | output | 8 | High address byte |
| ad_out | output | 8 | Value driven on the shared lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| ale | output | 1 | Address latch pulse |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 for IO, 0 for memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rdata | output | 8 | Byte captured on a read |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
On the last input clock of T3, the read-data capture and the release of the read strobe fall on the same edge. The bench holds the expected byte on ad_in up to that edge and replaces it with its complement just after. A correct capture then shows the original byte while rd_n is already high, and a capture one clock late shows the complement. A second overlap is the done pulse next to a start that is still held. There the bench checks that ale rises exactly two input clocks after done and not earlier.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [2:0] {
    K_OPF  = 3'd0,
    K_MRD  = 3'd1,
    K_MWR  = 3'd2,
    K_IORD = 3'd3,
    K_IOWR = 3'd4
  } kind_e;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_T4   = 3'd4
  } tstate_e;

  function automatic logic kind_valid(input logic [2:0] k);
    return k <= 3'd4;
  endfunction

  function automatic logic kind_reads(input logic [2:0] k);
    return (k == K_OPF) || (k == K_MRD) || (k == K_IORD);
  endfunction

  function automatic logic kind_io(input logic [2:0] k);
    return (k == K_IORD) || (k == K_IOWR);
  endfunction

  function automatic logic [1:0] kind_status(input logic [2:0] k);
    logic [1:0] s;
    case (k)
      K_OPF:          s = 2'b11;
      K_MRD, K_IORD:  s = 2'b10;
      K_MWR, K_IOWR:  s = 2'b01;
      default:        s = 2'b00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/mcs_clkdiv.sv
module mcs_clkdiv (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= ~tick;
  end

  p_tick_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (tick != $past(tick)));

endmodule

// File: rtl/mcs_tseq.sv
module mcs_tseq import mcs_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       start,
  input  logic [2:0] kind_in,
  output tstate_e    st,
  output logic [2:0] kind_q,
  output logic       accept,
  output logic       done
);

  assign accept = tick && (st == TS_IDLE) && start && kind_valid(kind_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= TS_IDLE;
      kind_q <= 3'd0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (st)
          TS_IDLE: if (accept) begin
            st     <= TS_T1;
            kind_q <= kind_in;
          end
          TS_T1: st <= TS_T2;
          TS_T2: st <= TS_T3;
          TS_T3: if (kind_q == K_OPF) st <= TS_T4;
                 else begin
                   st   <= TS_IDLE;
                   done <= 1'b1;
                 end
          TS_T4: begin
            st   <= TS_IDLE;
            done <= 1'b1;
          end
          default: st <= TS_IDLE;
        endcase
      end
    end
  end

  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_at_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (st == TS_IDLE));

  p_state_holds_off_tick_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tick)) |-> $stable(st));

endmodule

// File: rtl/mcs_busdrv.sv
module mcs_busdrv import mcs_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              accept,
  input  tstate_e           st,
  input  logic [2:0]        kind_q,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic              s1,
  output logic              s0,
  output logic [DATA_W-1:0] rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic busy, reads, strobe_phase, cap_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end

  assign busy         = (st != TS_IDLE);
  assign reads        = kind_reads(kind_q);
  assign strobe_phase = (st == TS_T2) || (st == TS_T3);
  assign cap_en       = tick && (st == TS_T3) && reads;

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (cap_en) rdata <= ad_in;
  end

  always_comb begin
    addr_hi  = addr_q[ADDR_W-1:DATA_W];
    ale      = (st == TS_T1);
    ad_oe    = (st == TS_T1) || (strobe_phase && !reads);
    ad_out   = (st == TS_T1) ? addr_q[DATA_W-1:0] : wdata_q;
    rd_n     = !(strobe_phase && reads);
    wr_n     = !(strobe_phase && !reads);
    io_m     = busy && kind_io(kind_q);
    {s1, s0} = busy ? kind_status(kind_q) : 2'b00;
  end

  p_ale_hands_to_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |-> (!rd_n || !wr_n));

  p_ale_strobes_idle_r4: assert property (@(posedge clk) disable iff (rst)
    ale |-> (rd_n && wr_n && ad_oe));

  p_rdata_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cap_en)) |-> $stable(rdata));

  p_status_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && busy && $past(busy)) |-> ($stable({s1, s0}) && $stable(io_m)));

  p_addr_holds_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && busy && $past(busy)) |-> $stable(addr_hi));

  p_no_dual_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

endmodule

// File: rtl/mux_bus_cycle_seq.sv
module mux_bus_cycle_seq import mcs_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        cyc_kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic              cpu_clk,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_m,
  output logic              s1,
  output logic              s0,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);

  logic       tick, accept;
  tstate_e    st;
  logic [2:0] kind_q;

  mcs_clkdiv u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  mcs_tseq u_seq (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .start   (start),
    .kind_in (cyc_kind),
    .st      (st),
    .kind_q  (kind_q),
    .accept  (accept),
    .done    (done)
  );

  mcs_busdrv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .accept  (accept),
    .st      (st),
    .kind_q  (kind_q),
    .addr    (addr),
    .wdata   (wdata),
    .ad_in   (ad_in),
    .addr_hi (addr_hi),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .ale     (ale),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .io_m    (io_m),
    .s1      (s1),
    .s0      (s0),
    .rdata   (rdata)
  );

  assign cpu_clk = tick;

endmodule

// File: tb/sim_mux_bus_cycle_seq.sv
module sim_mux_bus_cycle_seq;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, start;
  logic [2:0] cyc_kind;
  logic [15:0] addr;
  logic [7:0] wdata, ad_in;
  logic       cpu_clk, ad_oe, ale, rd_n, wr_n, io_m, s1, s0, done;
  logic [7:0] addr_hi, ad_out, rdata;

  int n_checks = 0;
  int n_err    = 0;
  logic [7:0] exp_rdata = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_cycle_seq u0 (
    .clk(clk), .rst(rst), .start(start), .cyc_kind(cyc_kind), .addr(addr),
    .wdata(wdata), .ad_in(ad_in), .cpu_clk(cpu_clk), .addr_hi(addr_hi),
    .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .io_m(io_m), .s1(s1), .s0(s0), .rdata(rdata), .done(done)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_status(input logic [2:0] k);
    if (k == 3'd0) return 2'b11;
    if (k == 3'd1 || k == 3'd3) return 2'b10;
    return 2'b01;
  endfunction

  task automatic t_reset();
    logic prev;
    rst = 1'b1; start = 1'b0; cyc_kind = 3'd0; addr = 16'h0; wdata = 8'h0; ad_in = 8'h0;
    repeat (3) @(negedge clk);
    chk(rd_n && wr_n, "R1 strobes high in reset", {rd_n, wr_n}, 2'b11);
    chk(!ale && !ad_oe, "R1 ale/oe low in reset", {ale, ad_oe}, 2'b00);
    chk({io_m, s1, s0, done} == 4'b0, "R1 io_m/status/done", {io_m, s1, s0, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({rd_n, wr_n, ale, ad_oe, io_m, s1, s0, done} == 8'b1100_0000,
        "R1 idle after reset", {rd_n, wr_n, ale, ad_oe, io_m, s1, s0, done}, 8'hC0);
    prev = cpu_clk;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(cpu_clk != prev, "R2 cpu_clk toggles each input clock", cpu_clk, ~prev);
      prev = cpu_clk;
    end
  endtask

  task automatic run_cycle(input logic [2:0] k, input logic [15:0] a,
                           input logic [7:0] wd, input logic [7:0] rv, input bit poke);
    bit rd_kind, io_kind, got;
    logic [1:0] stv;
    rd_kind = (k == 3'd0 || k == 3'd1 || k == 3'd3);
    io_kind = (k == 3'd3 || k == 3'd4);
    stv = exp_status(k);
    got = 1'b0;
    @(negedge clk);
    cyc_kind = k; addr = a; wdata = wd; ad_in = 8'h00; start = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (ale) begin got = 1'b1; break; end
    end
    start = 1'b0; addr = ~a; wdata = ~wd;
    chk(got, "R3 valid start accepted", got, 1);
    // T1, first half
    chk(addr_hi == a[15:8], "R4 T1 high address", addr_hi, a[15:8]);
    chk(ad_out == a[7:0] && ad_oe, "R4 T1 low address driven", ad_out, a[7:0]);
    chk(rd_n && wr_n, "R4 T1 strobes high", {rd_n, wr_n}, 2'b11);
    chk(io_m == io_kind, "R5 io_m in T1", io_m, io_kind);
    chk({s1, s0} == stv, "R5 status in T1", {s1, s0}, stv);
    @(negedge clk);
    if (poke) begin start = 1'b1; cyc_kind = 3'd0; end
    @(negedge clk); // T2
    chk(!ale, "R6 ale low in T2", ale, 0);
    if (rd_kind) begin
      chk(!rd_n && wr_n, "R6 read strobe low in T2", {rd_n, wr_n}, 2'b01);
      chk(!ad_oe, "R6 shared lines released in T2", ad_oe, 0);
      ad_in = rv;
    end else begin
      chk(!wr_n && rd_n, "R8 write strobe low in T2", {rd_n, wr_n}, 2'b10);
      chk(ad_oe && ad_out == wd, "R8 write byte driven in T2", ad_out, wd);
    end
    chk(addr_hi == a[15:8], "R11 high address held in T2", addr_hi, a[15:8]);
    @(negedge clk);
    if (poke) start = 1'b0;
    @(negedge clk); // T3
    if (rd_kind) chk(!rd_n && !ad_oe, "R6 read strobe low in T3", {rd_n, ad_oe}, 2'b00);
    else         chk(!wr_n && ad_out == wd, "R8 write held in T3", ad_out, wd);
    chk({s1, s0} == stv && io_m == io_kind, "R5 status held in T3", {io_m, s1, s0}, {io_kind, stv});
    chk(addr_hi == a[15:8], "R11 high address held in T3", addr_hi, a[15:8]);
    @(negedge clk);
    @(negedge clk);
    ad_in = ~rv;
    if (rd_kind) exp_rdata = rv;
    chk(rdata == exp_rdata, "R7 rdata after T3", rdata, exp_rdata);
    chk(rd_n && wr_n, "R6 strobes released after T3", {rd_n, wr_n}, 2'b11);
    if (k == 3'd0) begin
      chk(!ad_oe && !done, "R9 T4 bus released", {ad_oe, done}, 2'b00);
      chk({s1, s0} == 2'b11, "R9 T4 status held", {s1, s0}, 2'b11);
      @(negedge clk);
      @(negedge clk);
    end
    chk(done, "R10 done after final T-state", done, 1);
    chk(!ale && {s1, s0, io_m} == 3'b0, "R10 bus idle with done", {ale, s1, s0, io_m}, 0);
    chk(rdata == exp_rdata, "R7 rdata holds while idle", rdata, exp_rdata);
    @(negedge clk);
    chk(!done, "R10 done lasts one clock", done, 0);
    if (poke) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(!ale && {s1, s0} == 2'b00, "R3 start during cycle ignored", {ale, s1, s0}, 0);
      end
    end
  endtask

  task automatic t_opfetch(); run_cycle(3'd0, 16'h2005, 8'h00, 8'h3E, 1'b0); endtask
  task automatic t_memrd();   run_cycle(3'd1, 16'h2001, 8'h00, 8'hA7, 1'b0); endtask
  task automatic t_memwr();   run_cycle(3'd2, 16'h2065, 8'hC4, 8'h11, 1'b0); endtask
  task automatic t_iord();    run_cycle(3'd3, 16'h4181, 8'h00, 8'h6D, 1'b0); endtask
  task automatic t_iowr();    run_cycle(3'd4, 16'h81FE, 8'h9B, 8'h22, 1'b0); endtask
  task automatic t_busy_poke(); run_cycle(3'd2, 16'h1234, 8'h55, 8'h00, 1'b1); endtask

  task automatic t_invalid_kind();
    @(negedge clk);
    cyc_kind = 3'd5; start = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!ale && {s1, s0} == 2'b00 && rd_n && wr_n, "R3 invalid code starts nothing",
          {ale, s1, s0}, 0);
    end
    cyc_kind = 3'd7;
    repeat (2) @(negedge clk);
    chk(!ale && !done, "R3 code 7 starts nothing", {ale, done}, 0);
    start = 1'b0;
  endtask

  task automatic t_back_to_back();
    bit got;
    got = 1'b0;
    @(negedge clk);
    cyc_kind = 3'd1; addr = 16'h3C00; ad_in = 8'h5A; start = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (ale) begin got = 1'b1; break; end
    end
    chk(got, "R3 first back-to-back start", got, 1);
    repeat (6) @(negedge clk);
    exp_rdata = 8'h5A;
    chk(done && !ale, "R10 done before restart", {done, ale}, 2'b10);
    @(negedge clk);
    chk(!ale, "R10 no restart one clock after done", ale, 0);
    @(negedge clk);
    chk(ale && addr_hi == 8'h3C, "R10 held start accepted two clocks after done", ale, 1);
    start = 1'b0;
    got = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done) begin got = 1'b1; break; end
    end
    chk(got && rdata == 8'h5A, "R7 second back-to-back read completes", rdata, 8'h5A);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    n_checks++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_opfetch();
    t_memrd();
    t_memwr();
    t_iord();
    t_iowr();
    t_invalid_kind();
    t_busy_poke();
    t_back_to_back();
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule